// File: doc/BRIEF.md
# Reservation Station Bank with Broadcast Wakeup

This block holds a small group of reservation stations that sit in front of one kind of functional unit. An issue stage hands it an operation: an opcode, two source operands each given either as a value or as the tag of the station that will produce it. The bank places the operation in a free station and reports that station's tag, which becomes the tag of the operation's result.

Every cycle the bank watches the shared result bus. A station that is still missing an operand compares the broadcast tag with its pending producer tags. On a match it takes the broadcast data and stops waiting. When both operands are present, the station can be sent to the functional unit. If several stations are ready, the bank sends the one issued earliest, at most one per cycle. A station stays occupied while its operation executes. It is released when a result carrying its own tag appears on the bus. One configuration serves an adder bank of three stations (add or subtract) and another serves a multiplier bank of two.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free, `iss_ready` is 1, `iss_tag` is `BASE_TAG` and `disp_valid` is 0.
- R2: An accepted issue goes to the lowest-numbered free station. Station i has the result tag `BASE_TAG + i`, and `iss_tag` always shows the tag that the next issue would receive.
- R3: When every station is occupied, `iss_ready` is 0. An issue offered in that state is dropped and leaves no trace in any station.
- R4: A producer tag of 0 means the operand value is valid. A station is offered for dispatch only when both of its producer tags are 0.
- R5: When `bc_valid` is high, every occupied station whose pending tag equals `bc_tag` copies `bc_data` into that operand and marks the operand valid. A single broadcast can complete operands in several stations, and both operands of one station, in the same cycle.
- R6: An operand issued with a nonzero tag equal to the tag being broadcast in that same cycle is stored as a valid value holding `bc_data`.
- R7: Among the ready stations, the one issued earliest is offered on the dispatch port, whatever its station number. The port carries its opcode, its operands and its tag.
- R8: A dispatch happens when `disp_valid` and `disp_ready` are both high, and at most one happens per cycle. A dispatched station is never offered again.
- R9: A broadcast whose tag equals an occupied station's own tag frees that station from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_j_tag | input | TAG_W | Producer tag of the first operand, 0 when the value is given |
| iss_j_val | input | DATA_W | Value of the first operand |
| iss_k_tag | input | TAG_W | Producer tag of the second operand, 0 when the value is given |
| iss_k_val | input | DATA_W | Value of the second operand |
| iss_ready | output | 1 | A free station exists |
| iss_tag | output | TAG_W | Tag that the next accepted issue receives |
| bc_valid | input | 1 | The result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the station that produced the result |
| bc_data | input | DATA_W | Result value |
| disp_valid | output | 1 | A ready station is offered to the unit |
| disp_ready | input | 1 | The unit accepts the offered station |
| disp_op | output | OP_W | Opcode of the offered station |
| disp_a | output | DATA_W | First operand of the offered station |
| disp_b | output | DATA_W | Second operand of the offered station |
| disp_tag | output | TAG_W | Tag of the offered station |

## Verification
Two functions can fall in the same cycle. The first is the result bus capturing a missing operand. The second is either the issue of a new operation or the choice of which station to dispatch. The bench drives an issue whose source tag equals the tag on the bus in that same clock. It judges the case by whether the new station is offered for dispatch at once with the broadcast value. It also makes a younger station ready before an older one: it frees a low-numbered station, reissues into it, and then wakes the older station with a broadcast. The older station must win the dispatch port.

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int ENTRIES  = 3,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 2,
  parameter int TAG_W    = 3,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  input  logic [DATA_W-1:0] iss_k_val,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] busy, exec, rdy, pick;
  logic [ENTRIES-1:0] ahead [ENTRIES];
  logic [OP_W-1:0]    op_q  [ENTRIES];
  logic [DATA_W-1:0]  vj    [ENTRIES];
  logic [DATA_W-1:0]  vk    [ENTRIES];
  logic [TAG_W-1:0]   qj    [ENTRIES];
  logic [TAG_W-1:0]   qk    [ENTRIES];
  logic [IDX_W-1:0]   alloc_idx, disp_idx;

  always_comb begin
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) alloc_idx = IDX_W'(i);
  end

  assign iss_ready = ~&busy;
  assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);

  wire do_iss  = iss_valid && iss_ready;
  wire j_hit   = bc_valid && (iss_j_tag != '0) && (iss_j_tag == bc_tag);
  wire k_hit   = bc_valid && (iss_k_tag != '0) && (iss_k_tag == bc_tag);
  wire do_disp = disp_valid && disp_ready;

  always_comb begin
    disp_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (pick[i]) disp_idx = IDX_W'(i);
  end

  assign disp_valid = |pick;
  assign disp_op    = op_q[disp_idx];
  assign disp_a     = vj[disp_idx];
  assign disp_b     = vk[disp_idx];
  assign disp_tag   = TAG_W'(BASE_TAG) + TAG_W'(disp_idx);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [TAG_W-1:0] OWN = TAG_W'(BASE_TAG + g);
    assign rdy[g]  = busy[g] && !exec[g] && qj[g] == '0 && qk[g] == '0;
    assign pick[g] = rdy[g] && !(|(rdy & ahead[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[g]  <= 1'b0;
        exec[g]  <= 1'b0;
        ahead[g] <= '0;
        op_q[g]  <= '0;
        vj[g]    <= '0;
        vk[g]    <= '0;
        qj[g]    <= '0;
        qk[g]    <= '0;
      end else begin
        if (bc_valid && busy[g]) begin
          if (qj[g] != '0 && qj[g] == bc_tag) begin
            vj[g] <= bc_data;
            qj[g] <= '0;
          end
          if (qk[g] != '0 && qk[g] == bc_tag) begin
            vk[g] <= bc_data;
            qk[g] <= '0;
          end
          if (bc_tag == OWN) begin
            busy[g] <= 1'b0;
            exec[g] <= 1'b0;
          end
        end
        if (do_disp && pick[g]) exec[g] <= 1'b1;
        if (do_iss && alloc_idx == IDX_W'(g)) begin
          busy[g]  <= 1'b1;
          exec[g]  <= 1'b0;
          op_q[g]  <= iss_op;
          ahead[g] <= busy & ~(ENTRIES'(1) << g);
          qj[g]    <= j_hit ? '0 : iss_j_tag;
          vj[g]    <= j_hit ? bc_data : iss_j_val;
          qk[g]    <= k_hit ? '0 : iss_k_tag;
          vk[g]    <= k_hit ? bc_data : iss_k_val;
        end else if (do_iss) begin
          ahead[g][alloc_idx] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
  parameter int ENTRIES  = 3,
  parameter int TAG_W    = 3,
  parameter int BASE_TAG = 1,
  parameter int IDX_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [ENTRIES-1:0] busy,
  input logic [ENTRIES-1:0] exec,
  input logic [ENTRIES-1:0] pick,
  input logic [IDX_W-1:0]   alloc_idx,
  input logic [IDX_W-1:0]   disp_idx,
  input logic               disp_valid,
  input logic               disp_ready,
  input logic               bc_valid,
  input logic [TAG_W-1:0]   bc_tag
);
  a_r2_alloc_taken: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> busy[$past(alloc_idx)]);

  a_r3_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> $countones(busy) <= $past($countones(busy)));

  a_r8_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  a_r8_mark_exec: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> exec[$past(disp_idx)]);

  for (genvar k = 0; k < ENTRIES; k++) begin : g_free
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid && busy[k] && bc_tag == TAG_W'(BASE_TAG + k) |=> !busy[k]);
  end
endmodule

bind rs_bank rs_bank_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .busy(busy), .exec(exec), .pick(pick), .alloc_idx(alloc_idx),
  .disp_idx(disp_idx), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .bc_valid(bc_valid), .bc_tag(bc_tag)
);

// File: tb/rs_bank_test.sv
module rs_bank_test;
  logic        clk = 0, rst_n = 0;
  logic        iss_valid = 0, bc_valid = 0, disp_ready = 0;
  logic [1:0]  iss_op = 0;
  logic [2:0]  iss_j_tag = 0, iss_k_tag = 0, bc_tag = 0;
  logic [31:0] iss_j_val = 0, iss_k_val = 0, bc_data = 0;
  logic        iss_ready, disp_valid;
  logic [2:0]  iss_tag, disp_tag;
  logic [1:0]  disp_op;
  logic [31:0] disp_a, disp_b;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rs_bank uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [2:0] jt, logic [31:0] jv,
                       logic [2:0] kt, logic [31:0] kv);
    iss_valid = 1; iss_op = op;
    iss_j_tag = jt; iss_j_val = jv; iss_k_tag = kt; iss_k_val = kv;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic bcast(logic [2:0] t, logic [31:0] d);
    bc_valid = 1; bc_tag = t; bc_data = d;
    @(negedge clk);
    bc_valid = 0;
  endtask

  task automatic dispatch();
    disp_ready = 1;
    @(negedge clk);
    disp_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 iss_tag", iss_tag, 1);
  endtask

  task automatic t_fill();
    issue(1, 0, 'h10, 0, 'h20);
    chk("R2 second tag", iss_tag, 2);
    issue(2, 0, 'h11, 0, 'h21);
    chk("R2 third tag", iss_tag, 3);
    issue(3, 0, 'h12, 0, 'h22);
    chk("R3 full", iss_ready, 0);
    issue(0, 0, 'h99, 0, 'h99);
    chk("R7 first tag", disp_tag, 1);
    chk("R7 first a", disp_a, 'h10);
    chk("R7 first op", disp_op, 1);
    dispatch();
    chk("R8 next tag", disp_tag, 2);
    chk("R8 next a", disp_a, 'h11);
    dispatch();
    chk("R8 third tag", disp_tag, 3);
    chk("R8 third b", disp_b, 'h22);
    chk("R8 third op", disp_op, 3);
    dispatch();
    chk("R8 none left", disp_valid, 0);
    bcast(1, 0);
    chk("R9 freed ready", iss_ready, 1);
    chk("R9 freed tag", iss_tag, 1);
    bcast(2, 0);
    bcast(3, 0);
    chk("R3 dropped issue absent", disp_valid, 0);
  endtask

  task automatic t_wakeup();
    issue(1, 5, 0, 0, 'h30);
    issue(2, 5, 0, 5, 0);
    issue(1, 0, 'h40, 6, 0);
    chk("R4 waiting not offered", disp_valid, 0);
    bcast(5, 'h55);
    chk("R5 wake tag", disp_tag, 1);
    chk("R5 wake a", disp_a, 'h55);
    chk("R5 wake b", disp_b, 'h30);
    dispatch();
    chk("R5 both tag", disp_tag, 2);
    chk("R5 both a", disp_a, 'h55);
    chk("R5 both b", disp_b, 'h55);
    dispatch();
    chk("R4 k still waiting", disp_valid, 0);
    bcast(6, 'h66);
    chk("R5 late tag", disp_tag, 3);
    chk("R5 late b", disp_b, 'h66);
    chk("R5 late a", disp_a, 'h40);
    dispatch();
    bcast(1, 0); bcast(2, 0); bcast(3, 0);
    chk("R9 all free", iss_tag, 1);
  endtask

  task automatic t_age();
    issue(1, 0, 1, 0, 2);
    issue(2, 6, 0, 0, 3);
    chk("R7 only ready", disp_tag, 1);
    dispatch();
    bcast(1, 0);
    chk("R2 reuse low", iss_tag, 1);
    issue(3, 0, 7, 0, 8);
    bcast(6, 'h60);
    chk("R7 older wins tag", disp_tag, 2);
    chk("R7 older wins a", disp_a, 'h60);
    dispatch();
    chk("R7 younger next", disp_tag, 1);
    chk("R7 younger a", disp_a, 7);
    dispatch();
    chk("R8 drained", disp_valid, 0);
    bcast(1, 0); bcast(2, 0);
  endtask

  task automatic t_same();
    bc_valid = 1; bc_tag = 7; bc_data = 'h77;
    issue(2, 7, 0, 0, 5);
    bc_valid = 0;
    chk("R6 ready at issue", disp_valid, 1);
    chk("R6 captured a", disp_a, 'h77);
    chk("R6 b kept", disp_b, 5);
    dispatch();
    bcast(1, 0);
    chk("R9 final free", iss_ready, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_wakeup();
    t_age();
    t_same();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule